// File: doc/BRIEF.md
# Shadowed Nonvolatile SRAM Controller

This block models a 2048-word by 8-bit static RAM in which every word has a nonvolatile shadow copy. In normal operation the array works as a plain SRAM through a strobe-style port (active-low chip enable, output enable and write enable, an 11-bit address, and separate write and read data lanes with a drive-enable for the read lane). The port has no back-pressure. The `busy` pin is the only flow indication: while it is high, the port neither accepts writes nor drives read data, and the master is expected to wait.

There are two bulk transfers. A save copies the whole SRAM into the shadow array. A restore first clears every SRAM word and then copies the shadow array back in. A rising edge on the power-fail input starts a save. A rising edge on the power-good input starts a restore. Either transfer can also be started from software by issuing six reads at fixed addresses. Each transfer moves one word per clock. A power failure that arrives during a restore takes priority over it.

Top module: `nvsram_ctrl`

## Requirements
- R1: A write (ce_n=0, we_n=0) stores wdata at addr. A read (ce_n=0, oe_n=0, we_n=1) sampled on one clock edge presents that word on rdata, with rdata_oe high, after the same edge. Addresses 0 and 2047 behave like any other address.
- R2: rdata_oe stays low after any edge where ce_n is high, oe_n is high or we_n is low.
- R3: After reset, busy=0, rdata_oe=0 and rdata=0.
- R4: A rising edge of pwr_fail starts a save that copies every SRAM word to its shadow word. busy is high for exactly 2048 clock cycles.
- R5: A rising edge of pwr_good while idle starts a restore. busy is high for exactly 4096 cycles, and afterwards every SRAM word equals its shadow word.
- R6: A restore clears the SRAM in its first 2048 cycles and copies the shadow array in the next 2048. The shadow array is never written during a restore.
- R7: While busy, rdata_oe stays low and writes from the port are dropped.
- R8: Six reads with chip enable falling for each one, at addresses 0x4E3, 0x01C, 0x3E3, 0x41C, 0x303, 0x0FC in that order, start a save. busy rises after the edge that samples the sixth read.
- R9: The same sequence ending with 0x4C3 instead of 0x0FC starts a restore.
- R10: A write at any point in the sequence resets it, so the remaining reads start nothing.
- R11: A read at an address other than the expected one resets the sequence to its first step. If that address is 0x4E3, it counts as the first step.
- R12: A rising edge of pwr_fail during a restore abandons the restore and starts a full 2048-cycle save on the same edge. The SRAM words already cleared stay zero.
- R13: A rising edge of pwr_good while busy is ignored and is not remembered for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Word address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rdata_oe | output | 1 | Read-lane drive enable |
| pwr_fail | input | 1 | Power-down warning; rising edge starts a save |
| pwr_good | input | 1 | Power-up indication; rising edge starts a restore |
| busy | output | 1 | High while a save or restore runs |

## Verification
The hardest case to reach is a power failure that lands inside the clear phase of a restore. That phase cannot be seen at the ports: the SRAM contents are only visible once busy falls. The stimulus first saves one set of data. It then writes different values, starts a restore with pwr_good and raises pwr_fail ten cycles later. Afterwards it reads words deep inside the cleared region, which must be zero, and words far outside it, which must still hold the unsaved values. A second restore then shows that the save which took over captured that mixed state.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_STORE = 2'd1,
    XF_CLEAR = 2'd2,
    XF_COPY  = 2'd3
  } xf_state_t;

  // software trigger: five shared steps, then a tail picking the transfer
  localparam logic [10:0] TRIG_STEP0   = 11'h4E3;
  localparam logic [10:0] TRIG_STEP1   = 11'h01C;
  localparam logic [10:0] TRIG_STEP2   = 11'h3E3;
  localparam logic [10:0] TRIG_STEP3   = 11'h41C;
  localparam logic [10:0] TRIG_STEP4   = 11'h303;
  localparam logic [10:0] TRIG_SAVE    = 11'h0FC;
  localparam logic [10:0] TRIG_RESTORE = 11'h4C3;

endpackage

// File: rtl/nvs_word_array.sv
module nvs_word_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nvs_seq_detect.sv
module nvs_seq_detect
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              access,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              sw_store,
  output logic              sw_recall
);
  localparam logic [2:0] LAST_STEP = 3'd5;

  logic [2:0] step, step_nx;

  function automatic logic [ADDR_W-1:0] expect_addr(input logic [2:0] s);
    logic [10:0] a;
    case (s)
      3'd0:    a = TRIG_STEP0;
      3'd1:    a = TRIG_STEP1;
      3'd2:    a = TRIG_STEP2;
      3'd3:    a = TRIG_STEP3;
      default: a = TRIG_STEP4;
    endcase
    return ADDR_W'(a);
  endfunction

  always_comb begin
    step_nx   = step;
    sw_store  = 1'b0;
    sw_recall = 1'b0;
    if (hold) begin
      step_nx = 3'd0;
    end else if (access) begin
      if (acc_write) begin
        step_nx = 3'd0;
      end else if (step == LAST_STEP && acc_addr == ADDR_W'(TRIG_SAVE)) begin
        sw_store = 1'b1;
        step_nx  = 3'd0;
      end else if (step == LAST_STEP && acc_addr == ADDR_W'(TRIG_RESTORE)) begin
        sw_recall = 1'b1;
        step_nx   = 3'd0;
      end else if (step != LAST_STEP && acc_addr == expect_addr(step)) begin
        step_nx = step + 3'd1;
      end else if (acc_addr == expect_addr(3'd0)) begin
        step_nx = 3'd1;
      end else begin
        step_nx = 3'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step <= 3'd0;
    else        step <= step_nx;
  end
endmodule

// File: rtl/nvs_xfer_engine.sv
module nvs_xfer_engine
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fail_edge,
  input  logic              good_edge,
  input  logic              sw_store,
  input  logic              sw_recall,
  output xf_state_t         state,
  output logic [ADDR_W-1:0] idx,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] LAST_IDX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= XF_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        XF_IDLE: begin
          idx <= '0;
          if (fail_edge || sw_store)        state <= XF_STORE;
          else if (good_edge || sw_recall)  state <= XF_CLEAR;
        end
        XF_STORE: begin
          if (idx == LAST_IDX) begin
            state <= XF_IDLE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        XF_CLEAR: begin
          if (fail_edge) begin
            state <= XF_STORE;
            idx   <= '0;
          end else if (idx == LAST_IDX) begin
            state <= XF_COPY;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: begin
          if (fail_edge) begin
            state <= XF_STORE;
            idx   <= '0;
          end else if (idx == LAST_IDX) begin
            state <= XF_IDLE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy = (state != XF_IDLE);
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  input  logic              pwr_fail,
  input  logic              pwr_good,
  output logic              busy
);
  logic ce_q, fail_q, good_q;
  logic ce_fall, fail_edge, good_edge;
  logic sw_store, sw_recall;
  xf_state_t xf_state;
  logic [ADDR_W-1:0] idx;
  logic user_we, user_rd, restoring;
  logic sram_we, shadow_we;
  logic [ADDR_W-1:0] sram_waddr, sram_raddr;
  logic [DATA_W-1:0] sram_wd, sram_rd, shadow_rd;
  logic [DATA_W-1:0] rdata_q;
  logic rdata_oe_q;

  // edge detection on the strobe and the two power pins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q   <= 1'b1;
      fail_q <= 1'b0;
      good_q <= 1'b0;
    end else begin
      ce_q   <= ce_n;
      fail_q <= pwr_fail;
      good_q <= pwr_good;
    end
  end

  assign ce_fall   = ce_q & ~ce_n;
  assign fail_edge = pwr_fail & ~fail_q;
  assign good_edge = pwr_good & ~good_q;

  nvs_seq_detect #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (busy),
    .access    (ce_fall),
    .acc_write (~we_n),
    .acc_addr  (addr),
    .sw_store  (sw_store),
    .sw_recall (sw_recall)
  );

  nvs_xfer_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .fail_edge (fail_edge),
    .good_edge (good_edge),
    .sw_store  (sw_store),
    .sw_recall (sw_recall),
    .state     (xf_state),
    .idx       (idx),
    .busy      (busy)
  );

  // user port is live only while no transfer runs
  assign user_we   = ~busy & ~ce_n & ~we_n;
  assign user_rd   = ~busy & ~ce_n & ~oe_n & we_n;
  assign restoring = (xf_state == XF_CLEAR) || (xf_state == XF_COPY);

  // a fail edge pre-empts the restore write of that cycle
  assign sram_we    = user_we | (restoring & ~fail_edge);
  assign sram_waddr = busy ? idx : addr;
  assign sram_raddr = busy ? idx : addr;
  always_comb begin
    case (xf_state)
      XF_CLEAR: sram_wd = '0;
      XF_COPY:  sram_wd = shadow_rd;
      default:  sram_wd = wdata;
    endcase
  end

  assign shadow_we = (xf_state == XF_STORE);

  nvs_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sram (
    .clk   (clk),
    .we    (sram_we),
    .waddr (sram_waddr),
    .wdata (sram_wd),
    .raddr (sram_raddr),
    .rdata (sram_rd)
  );

  nvs_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
    .clk   (clk),
    .we    (shadow_we),
    .waddr (idx),
    .wdata (sram_rd),
    .raddr (idx),
    .rdata (shadow_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q    <= '0;
      rdata_oe_q <= 1'b0;
    end else begin
      rdata_oe_q <= user_rd;
      if (user_rd) rdata_q <= sram_rd;
    end
  end

  assign rdata    = rdata_q;
  assign rdata_oe = rdata_oe_q;
endmodule

// File: rtl/nvs_checker.sv
module nvs_checker
  import nvs_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      busy,
  input logic      rdata_oe,
  input logic      pwr_fail,
  input xf_state_t state,
  input logic      shadow_we
);
  // R7: no read data is driven after an edge that saw a transfer running
  a_r7_bus_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rdata_oe);

  // R6: the shadow array is untouched during either restore phase
  a_r6_shadow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XF_CLEAR || state == XF_COPY) |-> !shadow_we);

  // R6: the clear phase can only lead to copy, or to a save on power fail
  a_r6_clear_then_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XF_CLEAR) |=> (state == XF_CLEAR || state == XF_COPY || state == XF_STORE));

  // R4: a save runs on or returns to idle, never into a restore
  a_r4_store_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XF_STORE) |=> (state == XF_STORE || state == XF_IDLE));

  // R12: a fail edge during a restore switches to a save
  a_r12_fail_preempts: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == XF_CLEAR || state == XF_COPY) && pwr_fail && !$past(pwr_fail))
      |=> (state == XF_STORE));
endmodule

bind nvsram_ctrl nvs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .rdata_oe  (rdata_oe),
  .pwr_fail  (pwr_fail),
  .state     (xf_state),
  .shadow_we (shadow_we)
);

// File: tb/sim_nvsram_ctrl.sv
`timescale 1ns/1ps
module sim_nvsram_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rdata_oe, busy;
  logic pwr_fail = 1'b0, pwr_good = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] exp_val_q [$];
  bit         exp_care_q [$];
  string      exp_tag_q [$];

  always #5 clk = ~clk;

  nvsram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .pwr_fail(pwr_fail), .pwr_good(pwr_good), .busy(busy)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: pops one expected item per driven read word
  always @(negedge clk) begin
    if (rst_n && !done && rdata_oe === 1'b1) begin
      if (exp_val_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected rdata_oe actual=1 expected=0");
      end else begin
        logic [7:0] v; bit c; string t;
        v = exp_val_q.pop_front();
        c = exp_care_q.pop_front();
        t = exp_tag_q.pop_front();
        if (c) check(t, int'(rdata), int'(v));
      end
    end
  end

  task automatic do_write(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = a; wdata = d;
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic do_read(input logic [10:0] a, input logic [7:0] e,
                         input bit care, input string tag);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    exp_val_q.push_back(e); exp_care_q.push_back(care); exp_tag_q.push_back(tag);
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  // read that must not drive data; nothing queued
  task automatic quiet_read(input logic [10:0] a, input logic oe_v, input string tag);
    @(negedge clk); ce_n = 0; oe_n = oe_v; we_n = 1; addr = a;
    @(negedge clk); ce_n = 1; oe_n = 1;
    check(tag, int'(rdata_oe), 0);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic run_seq(input logic [10:0] tail);
    do_read(11'h4E3, 8'h00, 1'b0, "R8");
    do_read(11'h01C, 8'h00, 1'b0, "R8");
    do_read(11'h3E3, 8'h00, 1'b0, "R8");
    do_read(11'h41C, 8'h00, 1'b0, "R8");
    do_read(11'h303, 8'h00, 1'b0, "R8");
    do_read(tail,    8'h00, 1'b0, "R8");
  endtask

  task automatic idle_check(input string tag);
    repeat (4) @(negedge clk);
    check(tag, int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state
    check("R3 busy", int'(busy), 0);
    check("R3 rdata_oe", int'(rdata_oe), 0);
    check("R3 rdata", int'(rdata), 0);

    // R1 plain writes and reads, including both ends of the array
    do_write(11'd0, 8'h11); do_write(11'd1, 8'h22); do_write(11'd2, 8'h33);
    do_write(11'd3, 8'h44); do_write(11'd2047, 8'hA5); do_write(11'd5, 8'h55);
    for (int i = 0; i < 4; i++) do_write(11'(100 + i), 8'(8'hB0 + i));
    do_read(11'd0, 8'h11, 1'b1, "R1 addr0");
    do_read(11'd2047, 8'hA5, 1'b1, "R1 addr2047");
    do_read(11'd2, 8'h33, 1'b1, "R1 addr2");
    do_read(11'd101, 8'hB1, 1'b1, "R1 addr101");

    // R2 no drive with output enable high or during a write
    quiet_read(11'd0, 1'b1, "R2 oe_n high");
    do_write(11'd6, 8'h66);
    check("R2 write cycle", int'(rdata_oe), 0);

    // R8 software save
    run_seq(11'h0FC);
    count_busy(n);
    check("R8 save length", n, 2048);

    // R9 software restore brings back saved words
    do_write(11'd0, 8'hF0); do_write(11'd1, 8'hF1);
    run_seq(11'h4C3);
    count_busy(n);
    check("R9 restore length", n, 4096);
    do_read(11'd0, 8'h11, 1'b1, "R9 addr0");
    do_read(11'd1, 8'h22, 1'b1, "R9 addr1");
    do_read(11'd2047, 8'hA5, 1'b1, "R9 addr2047");

    // R10 a write inside the sequence aborts it
    do_read(11'h4E3, 8'h00, 1'b0, "R10");
    do_read(11'h01C, 8'h00, 1'b0, "R10");
    do_read(11'h3E3, 8'h00, 1'b0, "R10");
    do_write(11'd7, 8'h77);
    do_read(11'h41C, 8'h00, 1'b0, "R10");
    do_read(11'h303, 8'h00, 1'b0, "R10");
    do_read(11'h0FC, 8'h00, 1'b0, "R10");
    idle_check("R10 no save after write");

    // R11 mismatching read aborts; wrong tail starts nothing
    do_read(11'h4E3, 8'h00, 1'b0, "R11");
    do_read(11'h01C, 8'h00, 1'b0, "R11");
    do_read(11'h500, 8'h00, 1'b0, "R11");
    do_read(11'h3E3, 8'h00, 1'b0, "R11");
    do_read(11'h41C, 8'h00, 1'b0, "R11");
    do_read(11'h303, 8'h00, 1'b0, "R11");
    do_read(11'h0FC, 8'h00, 1'b0, "R11");
    idle_check("R11 no save after mismatch");
    run_seq(11'h123);
    idle_check("R11 no transfer on bad tail");
    // R11 repeated first address restarts at step one
    do_read(11'h4E3, 8'h00, 1'b0, "R11");
    run_seq(11'h0FC);
    count_busy(n);
    check("R11 restart then save", n, 2048);

    // R4 and R7 power-fail save with port traffic during busy
    @(negedge clk); pwr_fail = 1;
    @(negedge clk);
    check("R4 busy after fail edge", int'(busy), 1);
    do_write(11'd5, 8'hEE);
    quiet_read(11'd5, 1'b0, "R7 read blocked");
    count_busy(n);
    do_read(11'd5, 8'h55, 1'b1, "R7 write dropped");

    // R13 pwr_good edge during a save is ignored
    @(negedge clk); pwr_fail = 0;
    repeat (2) @(negedge clk); pwr_fail = 1;
    @(negedge clk); pwr_good = 1;
    count_busy(n);
    check("R4 R13 save length", n, 2048);
    idle_check("R13 no late restore");

    // R12 fail during restore clear phase
    @(negedge clk); pwr_fail = 0; pwr_good = 0;
    for (int i = 0; i < 4; i++) do_write(11'(i), 8'(8'hC0 + i));
    for (int i = 0; i < 4; i++) do_write(11'(100 + i), 8'(8'hD0 + i));
    @(negedge clk); pwr_good = 1;          // restore of the older save
    @(negedge clk);
    repeat (9) @(negedge clk);
    pwr_fail = 1;
    @(negedge clk);
    count_busy(n);
    check("R12 save after abort", n, 2048);
    for (int i = 0; i < 4; i++) do_read(11'(i), 8'h00, 1'b1, "R12 cleared word");
    for (int i = 0; i < 4; i++) do_read(11'(100 + i), 8'(8'hD0 + i), 1'b1, "R12 untouched word");

    // R5 and R6 fresh restore returns what the pre-empting save captured
    @(negedge clk); pwr_fail = 0; pwr_good = 0;
    for (int i = 0; i < 4; i++) do_write(11'(i), 8'h77);
    do_write(11'd101, 8'h99);
    @(negedge clk); pwr_good = 1;
    @(negedge clk);
    count_busy(n);
    check("R5 restore length", n, 4096);
    for (int i = 0; i < 4; i++) do_read(11'(i), 8'h00, 1'b1, "R5 R6 restored zero");
    for (int i = 0; i < 4; i++) do_read(11'(100 + i), 8'(8'hD0 + i), 1'b1, "R5 R6 restored word");

    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", exp_val_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule